// File: doc/BRIEF.md
# Subcode-Q Frame Capture and Host Serial Readout

This block collects the Q channel of a disc subcode stream, one bit per subcode frame. It assembles 96-bit Q frames and checks each one with a 16-bit CRC. Every frame that passes is handed to a host as 80 data bits over a simple serial port. The host sees a result flag for every completed frame. A high level on the serial data line, right after a good frame has been loaded, tells the host that fresh data is waiting.

The host drives a slow serial clock, and the block synchronizes that clock internally. Each rising edge shifts out the next data bit, and bytes leave in their received order with the least significant bit first. A retriggerable lockout counter runs on the system clock. The counter is held while the host clock is low and runs out a fixed number of cycles after it returns high. While it is running, a good frame does not overwrite the data the host is reading.

Top module: `subq_reader`

## Requirements
- R1: After reset, `sdo_o` and `crc_ok_o` are both 0.
- R2: A bit is taken only on a cycle with `q_vld_i` high. A frame begins with a taken bit that has `q_sync_i` high. Bit 0 of the frame is the data MSB, bits 0..79 are data, and bits 80..95 are the check field. Bits taken while no frame is open are ignored.
- R3: The check field must equal the bitwise inverse of the CRC-16 (polynomial x^16+x^12+x^5+1, zero start, MSB first) of the 80 data bits. `crc_ok_o` takes the result on the clock edge that samples bit 95 and keeps it until the next frame completes.
- R4: A passing frame completed outside the lockout is loaded on that same edge, and `sdo_o` is 1 after that edge.
- R5: Readout bit n (n = 0..79) is received data bit 8*(n/8) + 7 - (n mod 8). Byte order is kept, and the bits within each byte are reversed.
- R6: `sdo_o` presents the next readout bit on the third rising `clk` edge after `hclk_i` rises. It has not yet changed after the second edge.
- R7: After 80 host clock pulses, `sdo_o` holds readout bit 79 across further pulses until the next load.
- R8: The lockout is active while the synchronized host clock is low and for `LOCK_CYC` cycles after it goes high. A passing frame that completes during the lockout is discarded, and `crc_ok_o` still reports 1.
- R9: A failing frame sets `crc_ok_o` to 0 and leaves the readout register and `sdo_o` untouched.
- R10: A `q_sync_i` bit arriving in the middle of a frame abandons that frame and starts a new one at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_vld_i | input | 1 | Strobe: one Q bit on `q_bit_i` this cycle |
| q_sync_i | input | 1 | With `q_vld_i`, marks bit 0 of a Q frame |
| q_bit_i | input | 1 | Regenerated Q bit |
| hclk_i | input | 1 | Host serial clock, asynchronous, idles high |
| sdo_o | output | 1 | Serial data / new-data-ready indication |
| crc_ok_o | output | 1 | Result of the most recent frame check |

## Verification
Frame results (`crc_ok_o`, the load, and `sdo_o` going high) are due on the very edge that samples bit 95. The bench drives bits on falling edges and checks at the falling edge that follows the last bit. A serial bit is due on the third system-clock edge after `hclk_i` rises, because two synchronizer stages and one edge-detect stage lie in the path. The bench therefore samples two falling edges after the rise to see the old value, and three or more after the rise to see the new one. Lockout cases place a frame inside the `LOCK_CYC` window after a pulse, or wait well past it, so that the load decision can be predicted from cycle counts.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned SQ_DATA_BITS = 80;
  localparam int unsigned SQ_CRC_BITS  = 16;
  localparam logic [15:0] SQ_CRC_POLY  = 16'h1021;

  // one MSB-first CRC step for a single incoming bit
  function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic b);
    logic fb;
    fb = crc[15] ^ b;
    return {crc[14:0], 1'b0} ^ (fb ? SQ_CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/subq_hsync.sv
module subq_hsync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= async_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level_o = s2;
  assign rise_o  = s2 & ~s3;
endmodule

// File: rtl/subq_lockout.sv
module subq_lockout #(
  parameter int unsigned LOCK_CYC = 13500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hclk_s_i,
  output logic busy_o
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!hclk_s_i)      cnt <= LW'(LOCK_CYC);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign busy_o = !hclk_s_i || (cnt != '0);
endmodule

// File: rtl/subq_framer.sv
module subq_framer
  import subq_pkg::*;
#(
  parameter int unsigned DATA_BITS = SQ_DATA_BITS,
  parameter int unsigned CRC_BITS  = SQ_CRC_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic                 sync_i,
  input  logic                 bit_i,
  output logic                 done_o,
  output logic                 pass_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int unsigned FRAME_BITS = DATA_BITS + CRC_BITS;
  localparam int unsigned CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] IDLE = CW'(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] DEND = CW'(DATA_BITS);

  logic [FRAME_BITS-2:0] sp;
  logic [FRAME_BITS-1:0] sp_next;
  logic [CW-1:0]         cnt;
  logic [15:0]           crc;
  logic                  take;

  assign take    = vld_i && (sync_i || cnt != IDLE);
  assign sp_next = {sp, bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      cnt <= IDLE;
      crc <= '0;
    end else if (take) begin
      sp <= sp_next[FRAME_BITS-2:0];
      if (sync_i) begin
        cnt <= CW'(1);
        crc <= crc_step(16'h0000, bit_i);
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt < DEND) crc <= crc_step(crc, bit_i);
      end
    end
  end

  assign done_o = vld_i && !sync_i && (cnt == LAST);
  assign pass_o = done_o && (sp_next[CRC_BITS-1:0] == ~crc);
  assign data_o = sp_next[FRAME_BITS-1:CRC_BITS];
endmodule

// File: rtl/subq_readout.sv
module subq_readout #(
  parameter int unsigned DATA_BITS = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 shift_i,
  output logic                 sdo_o,
  output logic                 empty_o
);
  localparam int unsigned NBYTES = DATA_BITS / 8;
  localparam int unsigned LW = $clog2(DATA_BITS + 1);

  logic [DATA_BITS-1:0] rev;
  logic [DATA_BITS-1:0] rd;
  logic [LW-1:0]        left;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign rev[b*8+k] = data_i[b*8+7-k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd    <= '0;
      left  <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      rd    <= rev;
      left  <= LW'(DATA_BITS);
      sdo_o <= 1'b1;
    end else if (shift_i && left != '0) begin
      sdo_o <= rd[DATA_BITS-1];
      rd    <= {rd[DATA_BITS-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  assign empty_o = (left == '0);
endmodule

// File: rtl/subq_reader.sv
module subq_reader
  import subq_pkg::*;
#(
  parameter int unsigned DATA_BITS = SQ_DATA_BITS,
  parameter int unsigned CRC_BITS  = SQ_CRC_BITS,
  parameter int unsigned LOCK_CYC  = 13500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic q_vld_i,
  input  logic q_sync_i,
  input  logic q_bit_i,
  input  logic hclk_i,
  output logic sdo_o,
  output logic crc_ok_o
);
  logic                 frame_done;
  logic                 frame_pass;
  logic [DATA_BITS-1:0] frame_data;
  logic                 hclk_s;
  logic                 host_rise;
  logic                 lock_busy;
  logic                 load_ev;
  logic                 rd_empty;

  subq_framer #(.DATA_BITS(DATA_BITS), .CRC_BITS(CRC_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .vld_i(q_vld_i), .sync_i(q_sync_i), .bit_i(q_bit_i),
    .done_o(frame_done), .pass_o(frame_pass), .data_o(frame_data)
  );

  subq_hsync u_hsync (
    .clk(clk), .rst_n(rst_n), .async_i(hclk_i), .level_o(hclk_s), .rise_o(host_rise)
  );

  subq_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .hclk_s_i(hclk_s), .busy_o(lock_busy)
  );

  assign load_ev = frame_pass && !lock_busy;

  subq_readout #(.DATA_BITS(DATA_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .load_i(load_ev), .data_i(frame_data),
    .shift_i(host_rise), .sdo_o(sdo_o), .empty_o(rd_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_ok_o <= 1'b0;
    else if (frame_done) crc_ok_o <= frame_pass;
  end
endmodule

// File: rtl/subq_reader_chk.sv
module subq_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_done,
  input logic frame_pass,
  input logic hclk_s,
  input logic host_rise,
  input logic lock_busy,
  input logic load_ev,
  input logic rd_empty,
  input logic sdo_o,
  input logic crc_ok_o
);
  // R4
  load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> sdo_o);

  // R8
  lock_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> !load_ev);

  // R8
  low_clock_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hclk_s |-> lock_busy);

  // R3
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(crc_ok_o));

  // R9
  fail_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_pass |=> !crc_ok_o);

  // R6
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev && !host_rise |=> $stable(sdo_o));

  // R7
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty && !load_ev |=> $stable(sdo_o));
endmodule

bind subq_reader subq_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_pass(frame_pass),
  .hclk_s(hclk_s), .host_rise(host_rise), .lock_busy(lock_busy), .load_ev(load_ev),
  .rd_empty(rd_empty), .sdo_o(sdo_o), .crc_ok_o(crc_ok_o)
);

// File: tb/subq_reader_tb.sv
module subq_reader_tb;
  localparam int LOCK = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_vld = 1'b0, q_sync = 1'b0, q_bit = 1'b0, hclk = 1'b1;
  logic sdo, crc_ok;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  subq_reader #(.LOCK_CYC(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_vld_i(q_vld), .q_sync_i(q_sync), .q_bit_i(q_bit),
    .hclk_i(hclk), .sdo_o(sdo), .crc_ok_o(crc_ok)
  );

  function automatic logic [95:0] make_frame(input logic [79:0] d);
    logic [95:0] r;
    r = {d, 16'h0000};
    for (int i = 95; i >= 16; i--)
      if (r[i]) r[i -: 17] = r[i -: 17] ^ 17'h11021;
    return {d, ~r[15:0]};
  endfunction

  function automatic logic exp_bit(input logic [79:0] d, input int n);
    int idx;
    idx = (n / 8) * 8 + 7 - (n % 8);
    return d[79 - idx];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [95:0] f, input int n, input bit with_sync);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      q_vld = 1'b1;
      q_sync = with_sync && (i == 0);
      q_bit = f[95 - i];
    end
    @(negedge clk);
    q_vld = 1'b0;
    q_sync = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk) hclk = 1'b0;
    repeat (4) @(negedge clk);
    hclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_lock();
    repeat (LOCK + 10) @(negedge clk);
  endtask

  task automatic read_range(input string req, input logic [79:0] d, input int from, input int to);
    for (int n = from; n <= to; n++) begin
      pulse();
      check(req, sdo, exp_bit(d, n));
    end
  endtask

  localparam logic [79:0] DA = 80'h1234_5678_9ABC_DEF0_0FF0;
  localparam logic [79:0] DB = 80'hA55A_3C96_0F1E_8421_7E81;
  localparam logic [79:0] DC = 80'hFEDC_BA98_7654_3210_C3A5;

  task automatic t_reset();
    check("R1 sdo", sdo, 1'b0);
    check("R1 crc_ok", crc_ok, 1'b0);
  endtask

  task automatic t_nosync();
    send_bits(make_frame(DA), 96, 1'b0);
    check("R2 unsynced flag", crc_ok, 1'b0);
    check("R2 unsynced sdo", sdo, 1'b0);
  endtask

  task automatic t_load_read();
    send_bits(make_frame(DA), 96, 1'b1);
    check("R3 good flag", crc_ok, 1'b1);
    check("R4 ready high", sdo, 1'b1);
    // R6 latency on first bit (expected 0, ready level 1)
    @(negedge clk) hclk = 1'b0;
    repeat (4) @(negedge clk);
    hclk = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 not yet", sdo, 1'b1);
    @(negedge clk);
    check("R6 due", sdo, exp_bit(DA, 0));
    repeat (2) @(negedge clk);
    read_range("R5", DA, 1, 79);
    pulse();
    check("R7 hold", sdo, exp_bit(DA, 79));
    pulse();
    check("R7 hold2", sdo, exp_bit(DA, 79));
  endtask

  task automatic t_bad();
    logic [95:0] f;
    idle_lock();
    f = make_frame(DB);
    f[40] = ~f[40];
    send_bits(f, 96, 1'b1);
    check("R9 bad flag", crc_ok, 1'b0);
    check("R9 sdo kept", sdo, exp_bit(DA, 79));
    pulse();
    check("R9 no load", sdo, exp_bit(DA, 79));
  endtask

  task automatic t_resync();
    idle_lock();
    send_bits(make_frame(DB), 40, 1'b1);
    send_bits(make_frame(DC), 96, 1'b1);
    check("R10 flag", crc_ok, 1'b1);
    check("R10 ready", sdo, 1'b1);
    read_range("R10 data", DC, 0, 15);
  endtask

  task automatic t_lock();
    idle_lock();
    send_bits(make_frame(DA), 96, 1'b1);
    check("R4 reload", sdo, 1'b1);
    read_range("R5 partial", DA, 0, 2);
    send_bits(make_frame(DB), 96, 1'b1);
    check("R8 flag", crc_ok, 1'b1);
    check("R8 sdo kept", sdo, exp_bit(DA, 2));
    read_range("R8 old data", DA, 3, 10);
    idle_lock();
    send_bits(make_frame(DB), 96, 1'b1);
    check("R8 after expiry", sdo, 1'b1);
    read_range("R5 B", DB, 0, 79);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nosync();
    t_load_read();
    t_bad();
    t_resync();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule